// File: doc/BRIEF.md
# Four-Bit ADPCM Sample Decoder

This block turns a stream of packed 4-bit adaptive differential codes into signed 16-bit PCM samples. Bytes arrive on a valid/ready handshake. Each byte carries two codes, and the block decodes one code per clock while a byte is held. The decoder keeps two pieces of state: a running signal value and an adaptive quantiser step. Each code scales the step by an odd multiplier to form a difference, adds that difference to the signal with saturation, and then rescales the step by a factor taken from a small table, clamping the result to a fixed range.

A voice that loops back to a point inside its sample data would otherwise have to decode again from the beginning to rebuild the state at that point. To avoid this, the block counts decoded codes. When the count reaches a programmable loop-start index, it copies the live signal and step into a snapshot. A loop-restore pulse loads the live state from the snapshot and sets the code count back to the loop index. The upstream fetch logic then resupplies bytes starting with the byte that holds that code. When the index is odd, decoding starts at that byte's upper nibble. A restart pulse returns the decoder to its initial state.

Top module: `adpcm4_decoder`

## Requirements
- R1: After reset or a restart pulse, `out_valid` is low, and `in_ready` is high once the pulse is gone. The live state is signal 0 and step 0x7F, and the snapshot holds these same values.
- R2: Code bits [2:0] select the magnitude multiplier 2*c+1 (1, 3, …, 15). Bit [3] set makes the multiplier negative.
- R3: The difference is step × multiplier divided by 8, truncated toward zero. For example, code 8 from the initial state yields -15, not -16. The difference is added to the previous signal.
- R4: The sum saturates to the range -32768 to 32767.
- R5: The new step is (step × factor) >> 8. The factor is 230 for code bits [2:0] of 0–3, and 307, 409, 512, 614 for 4, 5, 6, 7.
- R6: After scaling, the step is clamped to the range 0x7F to 0x6000.
- R7: Within a byte, bits [3:0] are decoded before bits [7:4].
- R8: When a code is decoded while the code count equals `loop_idx`, the state before that code is saved. A `loop_restore` pulse reloads the live state from the snapshot and sets the count to `loop_idx`. If `loop_idx` is odd, the next byte accepted decodes only its upper nibble.
- R9: `in_ready` is low only while a held byte still has its lower nibble pending, or during a restart or restore cycle. With input always valid, a new sample appears on every clock.
- R10: A restart pulse discards a partly consumed byte. Its remaining nibble produces no sample.
- R11: Every decoded code produces exactly one `out_valid` cycle, with samples in code order. A sample appears one clock after the code is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Pulse: return to initial decoder state, drop held byte |
| loop_restore | input | 1 | Pulse: reload live state from the loop snapshot |
| loop_idx | input | IDX_W | Code index at which the snapshot is taken |
| in_byte | input | 8 | Two packed codes, lower nibble first |
| in_valid | input | 1 | `in_byte` is valid |
| in_ready | output | 1 | Block accepts `in_byte` this cycle |
| out_sample | output | 16 | Decoded signed sample |
| out_valid | output | 1 | `out_sample` holds a new sample |

## Verification
The bench drives the first negative code from the initial step. A decoder that floors the difference instead of truncating it gives -16 where -15 is expected. Long runs of maximal codes push the signal to both rails and the step to its ceiling. A missing saturation makes the signal wrap, and a missing clamp makes the next difference too large. A step below 0x7F after a shrinking code is also caught, because the following difference comes out too small. Several further cases each expose a specific fault:
- **Loop restore at an odd index.** Restoring at index 3 must reproduce the first-pass samples exactly. A decoder that misses the snapshot, or restarts at the lower nibble, gives different values.
- **Restart in mid-byte.** Restarting between the two nibbles of a byte must drop the upper nibble. A leaked nibble shows up as an extra sample.
- **Sustained input.** Continuous input must give back-to-back outputs. A decoder that stalls after every byte loses one cycle in three.

// File: rtl/adpcm4_pkg.sv
package adpcm4_pkg;

    localparam int SMP_W    = 16;
    localparam int STEP_W   = 15;
    localparam int FACT_W   = 10;
    localparam int FRAC_W   = 8;
    localparam int CODE_W   = 4;
    localparam int BYTE_W   = 2 * CODE_W;

    localparam logic [STEP_W-1:0] STEP_MIN = STEP_W'(16'h007F);
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(16'h6000);

    typedef struct packed {
        logic signed [SMP_W-1:0] sig;
        logic [STEP_W-1:0]       step;
    } dec_state_t;

    localparam dec_state_t STATE_INIT = '{sig: '0, step: STEP_MIN};

    // odd magnitude multiplier 2*c+1 selected by the low three code bits
    function automatic logic [CODE_W-1:0] odd_mult(input logic [CODE_W-2:0] c);
        return {c, 1'b1};
    endfunction

    // step scale factor, 8 fractional bits
    function automatic logic [FACT_W-1:0] step_factor(input logic [CODE_W-2:0] c);
        logic [FACT_W-1:0] f;
        case (c)
            3'd4:    f = FACT_W'(307);
            3'd5:    f = FACT_W'(409);
            3'd6:    f = FACT_W'(512);
            3'd7:    f = FACT_W'(614);
            default: f = FACT_W'(230);
        endcase
        return f;
    endfunction

endpackage

// File: rtl/adpcm4_nibble_feeder.sv
module adpcm4_nibble_feeder
    import adpcm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              flush_hi,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              code_vld,
    output logic [CODE_W-1:0] code,
    output logic              holding
);
    logic              have_q;
    logic              hi_q;
    logic [BYTE_W-1:0] byte_q;

    assign in_ready = !flush && (!have_q || hi_q);
    assign code_vld = have_q && !flush;
    assign code     = hi_q ? byte_q[BYTE_W-1:CODE_W] : byte_q[CODE_W-1:0];
    assign holding  = have_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            hi_q   <= 1'b0;
            byte_q <= '0;
        end else if (flush) begin
            have_q <= 1'b0;
            hi_q   <= flush_hi;
        end else if (have_q && hi_q) begin
            // upper nibble consumed this cycle; refill if possible
            hi_q <= 1'b0;
            if (in_valid) begin
                byte_q <= in_byte;
                have_q <= 1'b1;
            end else begin
                have_q <= 1'b0;
            end
        end else if (have_q) begin
            hi_q <= 1'b1;
        end else if (in_valid) begin
            byte_q <= in_byte;
            have_q <= 1'b1;
        end
    end
endmodule

// File: rtl/adpcm4_step_unit.sv
module adpcm4_step_unit
    import adpcm4_pkg::*;
(
    input  dec_state_t        cur,
    input  logic [CODE_W-1:0] code,
    output dec_state_t        nxt
);
    localparam int PW = STEP_W + CODE_W;
    localparam int SW = ((PW > SMP_W) ? PW : SMP_W) + 2;
    localparam int QW = STEP_W + FACT_W;

    localparam logic signed [SW-1:0] SMAX = SW'((64'sd1 <<< (SMP_W - 1)) - 1);
    localparam logic signed [SW-1:0] SMIN = -SMAX - 1;

    logic [PW-1:0]        prod;
    logic [PW-1:0]        mag;
    logic signed [SW-1:0] sig_e;
    logic signed [SW-1:0] mag_e;
    logic signed [SW-1:0] sum;
    logic [QW-1:0]        qprod;
    logic [QW-1:0]        qscaled;

    always_comb begin
        // difference magnitude, truncated toward zero by working on |x|
        prod  = PW'(cur.step) * PW'(odd_mult(code[CODE_W-2:0]));
        mag   = prod >> 3;
        sig_e = SW'(cur.sig);
        mag_e = SW'(mag);
        sum   = code[CODE_W-1] ? (sig_e - mag_e) : (sig_e + mag_e);

        if (sum > SMAX)      nxt.sig = SMP_W'(SMAX);
        else if (sum < SMIN) nxt.sig = SMP_W'(SMIN);
        else                 nxt.sig = SMP_W'(sum);

        qprod   = QW'(cur.step) * QW'(step_factor(code[CODE_W-2:0]));
        qscaled = qprod >> FRAC_W;

        if (qscaled < QW'(STEP_MIN))      nxt.step = STEP_MIN;
        else if (qscaled > QW'(STEP_MAX)) nxt.step = STEP_MAX;
        else                              nxt.step = STEP_W'(qscaled);
    end
endmodule

// File: rtl/adpcm4_state_bank.sv
module adpcm4_state_bank
    import adpcm4_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             loop_restore,
    input  logic [IDX_W-1:0] loop_idx,
    input  logic             code_vld,
    input  dec_state_t       nxt,
    output dec_state_t       live,
    output dec_state_t       snap
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            live  <= STATE_INIT;
            snap  <= STATE_INIT;
            idx_q <= '0;
        end else if (loop_restore) begin
            live  <= snap;
            idx_q <= loop_idx;
        end else if (code_vld) begin
            if (idx_q == loop_idx) begin
                snap <= live;
            end
            live  <= nxt;
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/adpcm4_decoder.sv
module adpcm4_decoder
    import adpcm4_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    loop_restore,
    input  logic [IDX_W-1:0]        loop_idx,
    input  logic [BYTE_W-1:0]       in_byte,
    input  logic                    in_valid,
    output logic                    in_ready,
    output logic signed [SMP_W-1:0] out_sample,
    output logic                    out_valid
);
    logic              flush;
    logic              flush_hi;
    logic              code_vld;
    logic [CODE_W-1:0] code;
    logic              holding;
    dec_state_t        cur_st;
    dec_state_t        nxt_st;
    dec_state_t        snap_st;

    assign flush    = restart || loop_restore;
    assign flush_hi = !restart && loop_idx[0];

    adpcm4_nibble_feeder u_feed (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .flush_hi (flush_hi),
        .in_byte  (in_byte),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .code_vld (code_vld),
        .code     (code),
        .holding  (holding)
    );

    adpcm4_step_unit u_step (
        .cur  (cur_st),
        .code (code),
        .nxt  (nxt_st)
    );

    adpcm4_state_bank #(.IDX_W(IDX_W)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .loop_restore (loop_restore),
        .loop_idx     (loop_idx),
        .code_vld     (code_vld),
        .nxt          (nxt_st),
        .live         (cur_st),
        .snap         (snap_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= code_vld;
            if (code_vld) begin
                out_sample <= nxt_st.sig;
            end
        end
    end
endmodule

// File: rtl/adpcm4_checker.sv
module adpcm4_checker
    import adpcm4_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    restart,
    input logic                    loop_restore,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    holding,
    input logic signed [SMP_W-1:0] live_sig,
    input logic [STEP_W-1:0]       live_step,
    input logic signed [SMP_W-1:0] snap_sig,
    input logic [STEP_W-1:0]       snap_step
);
    // R1: restart leaves the initial state and no output
    a_r1_restart_init: assert property (@(posedge clk) disable iff (rst)
        restart |=> (live_sig == '0 && live_step == STEP_MIN && !out_valid));

    // R6: step never leaves its clamp range
    a_r6_step_range: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (live_step >= STEP_MIN && live_step <= STEP_MAX));

    // R8: restore reloads live state from the snapshot
    a_r8_restore_loads: assert property (@(posedge clk) disable iff (rst)
        (loop_restore && !restart) |=>
            (live_sig == $past(snap_sig) && live_step == $past(snap_step)));

    // R9: an accepted byte is held on the next cycle
    a_r9_accept_holds: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> holding);

    // R11: a sample only follows a cycle in which a byte was held
    a_r11_valid_needs_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(holding));
endmodule

bind adpcm4_decoder adpcm4_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .restart      (restart),
    .loop_restore (loop_restore),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .holding      (holding),
    .live_sig     (cur_st.sig),
    .live_step    (cur_st.step),
    .snap_sig     (snap_st.sig),
    .snap_step    (snap_st.step)
);

// File: tb/adpcm4_decoder_tb_top.sv
module adpcm4_decoder_tb_top;
    localparam int IDX_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              restart = 1'b0;
    logic              loop_restore = 1'b0;
    logic [IDX_W-1:0]  loop_idx = '0;
    logic [7:0]        in_byte = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic signed [15:0] out_sample;
    logic              out_valid;

    adpcm4_decoder #(.IDX_W(IDX_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .loop_restore (loop_restore),
        .loop_idx     (loop_idx),
        .in_byte      (in_byte),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .out_sample   (out_sample),
        .out_valid    (out_valid)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_q[$];
    int seen[$];
    int seen_cyc[$];
    string cur_req = "R11";

    // reference model state
    int m_sig = 0, m_step = 127, m_idx = 0, m_hi = 0;
    int m_snap_sig = 0, m_snap_step = 127, m_loop = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sig = 0; m_step = 127; m_idx = 0; m_hi = 0;
        m_snap_sig = 0; m_snap_step = 127;
    endtask

    task automatic model_code(input logic [3:0] c);
        int mul, d, fac;
        if (m_idx == m_loop) begin
            m_snap_sig = m_sig; m_snap_step = m_step;
        end
        mul = 2 * int'(c[2:0]) + 1;
        d = (m_step * mul) / 8;
        m_sig = c[3] ? m_sig - d : m_sig + d;
        if (m_sig > 32767) m_sig = 32767;
        if (m_sig < -32768) m_sig = -32768;
        case (c[2:0])
            3'd4: fac = 307;
            3'd5: fac = 409;
            3'd6: fac = 512;
            3'd7: fac = 614;
            default: fac = 230;
        endcase
        m_step = (m_step * fac) / 256;
        if (m_step < 127) m_step = 127;
        if (m_step > 24576) m_step = 24576;
        m_idx = (m_idx + 1) & 16'hFFFF;
        exp_q.push_back(m_sig);
    endtask

    task automatic accept(input logic [7:0] b);
        @(negedge clk);
        in_byte = b; in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        accept(b);
        if (m_hi != 0) begin
            model_code(b[7:4]);
            m_hi = 0;
        end else begin
            model_code(b[3:0]);
            model_code(b[7:4]);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        model_reset();
    endtask

    task automatic pulse_restore();
        @(negedge clk);
        loop_restore = 1'b1;
        @(negedge clk);
        loop_restore = 1'b0;
        m_sig = m_snap_sig; m_step = m_snap_step;
        m_idx = m_loop; m_hi = m_loop & 1;
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", int'(out_sample), 99999);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(out_sample) == e, cur_req, int'(out_sample), e);
            end
            seen.push_back(int'(out_sample));
            seen_cyc.push_back(cyc);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base, b2, s3, s4, s5;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

        // R2 / R7: first byte from the initial state
        cur_req = "R2";
        pulse_restart();
        base = seen.size();
        send_byte(8'h87);
        drain();
        chk(seen[base] == 238, "R2", seen[base], 238);
        chk(seen[base+1] == 200, "R7", seen[base+1], 200);

        // R3 truncation toward zero, R6 lower clamp
        cur_req = "R3";
        pulse_restart();
        base = seen.size();
        send_byte(8'h08);
        drain();
        chk(seen[base] == -15, "R3", seen[base], -15);
        chk(seen[base+1] == 0, "R6", seen[base+1], 0);

        // R5 factors
        cur_req = "R5";
        pulse_restart();
        base = seen.size();
        send_byte(8'h54);
        send_byte(8'h36);
        drain();
        chk(seen[base] == 142, "R5", seen[base], 142);
        chk(seen[base+3] == 1167, "R5", seen[base+3], 1167);

        // R4 saturation at both rails, R6 upper clamp
        cur_req = "R4";
        pulse_restart();
        for (int i = 0; i < 6; i++) send_byte(8'h77);
        drain();
        chk(seen[seen.size()-1] == 32767, "R4", seen[seen.size()-1], 32767);
        for (int i = 0; i < 4; i++) send_byte(8'hFF);
        drain();
        chk(seen[seen.size()-1] == -32768, "R4", seen[seen.size()-1], -32768);
        cur_req = "R6";
        base = seen.size();
        send_byte(8'h11);
        drain();
        chk(seen[base] == -23552, "R6", seen[base], -23552);
        chk(seen[base+1] == -15272, "R6", seen[base+1], -15272);

        // R9 stall and throughput
        cur_req = "R9";
        pulse_restart();
        send_byte(8'h21);
        chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
        @(posedge clk);
        #1;
        chk(in_ready == 1'b1, "R9", int'(in_ready), 1);
        drain();
        base = seen.size();
        for (int i = 0; i < 8; i++) send_byte(8'(8'h13 + 8'(i * 37)));
        drain();
        chk(seen_cyc[base+15] - seen_cyc[base] == 15, "R9",
            seen_cyc[base+15] - seen_cyc[base], 15);

        // R8 snapshot at odd index and restore
        cur_req = "R8";
        loop_idx = 16'd3;
        m_loop = 3;
        pulse_restart();
        base = seen.size();
        send_byte(8'h4A);
        send_byte(8'h7C);
        send_byte(8'h19);
        drain();
        s3 = seen[base+3]; s4 = seen[base+4]; s5 = seen[base+5];
        for (int k = 0; k < 2; k++) begin
            pulse_restore();
            b2 = seen.size();
            send_byte(8'h7C);
            send_byte(8'h19);
            drain();
            chk(seen.size() - b2 == 3, "R8", seen.size() - b2, 3);
            chk(seen[b2] == s3, "R8", seen[b2], s3);
            chk(seen[b2+1] == s4, "R8", seen[b2+1], s4);
            chk(seen[b2+2] == s5, "R8", seen[b2+2], s5);
        end
        loop_idx = '0;
        m_loop = 0;

        // R10 restart between nibbles drops the upper nibble
        cur_req = "R10";
        pulse_restart();
        base = seen.size();
        accept(8'h35);
        model_code(4'h5);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(seen.size() - base == 1, "R10", seen.size() - base, 1);
        send_byte(8'h07);
        drain();
        chk(seen[seen.size()-1] == 276, "R10", seen[seen.size()-1], 276);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // R11 every expected sample arrived
        chk(exp_q.size() == 0, "R11", exp_q.size(), 0);
        finish_run();
    end
endmodule